// File: doc/BRIEF.md
# Linearized Early-Late Phase Detector

This block is the phase detector in a clock-data recovery loop. Serial NRZ data is sampled twice in each bit period. The rising edge of the recovered clock is meant to fall at the centre of each bit, and the falling edge at the boundary between bits. From the two latest centre samples and the boundary sample taken between them, the detector decides whether the clock leads or trails the data. It reports this as a polarity.

That polarity is then gated by a linearizing term: the exclusive-OR of the live input and its most recent rising-edge sample. An output pulse therefore lasts from the moment the data changes until the next rising clock edge, so its width carries the magnitude of the phase offset. The early and late outputs feed a charge pump, which is not part of this block.

Top module: `lin_el_pd`

## Requirements
- R1: While `rst_ni` is low, both `early_o` and `late_o` are low, immediately and independently of the clock. All sample registers clear to 0, so constant-low data after release gives no pulse.
- R2: If the two most recent rising-edge (centre) samples are equal, both outputs stay low for the whole following bit period.
- R3: If those two centre samples differ and the falling-edge (boundary) sample taken between them equals the older centre sample, the decision is early. Only `early_o` may then pulse.
- R4: If those two centre samples differ and the boundary sample equals the newer centre sample, the decision is late. Only `late_o` may then pulse.
- R5: `early_o` and `late_o` are never high at the same time.
- R6: An output is high only while `data_i` differs from its most recent rising-edge sample. With an active decision, the pulse starts when `data_i` changes and ends at the next rising clock edge, so its width equals that interval.
- R7: A data change within a bit period gives no pulse when the preceding two centre samples are equal. The polarity comes only from the stored-sample decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Recovered clock; rising edge samples bit centres, falling edge samples bit boundaries |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 1 | Serial NRZ data |
| early_o | output | 1 | Clock-early pulse, width proportional to phase offset |
| late_o | output | 1 | Clock-late pulse, width proportional to phase offset |

## Verification
The hardest case to reach is the handover between a decision and the linearizing gate. A pulse appears only when a transition in one bit period is followed directly by another in the next bit. A change right after a long run of equal bits must stay silent. The bench reaches this by moving the data edge to chosen offsets within each clock period. It places isolated transitions, back-to-back toggles and sudden offset changes, then counts the high samples on each output at sub-cycle steps to measure pulse width.

// File: rtl/lin_el_pd_pkg.sv
package lin_el_pd_pkg;

  typedef struct packed {
    logic prev_ctr;
    logic bnd;
    logic cur_ctr;
  } pd_samples_t;

  typedef enum logic [1:0] {
    PD_NONE  = 2'b00,
    PD_EARLY = 2'b01,
    PD_LATE  = 2'b10
  } pd_dir_e;

endpackage

// File: rtl/pd_sampler.sv
module pd_sampler
  import lin_el_pd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        data_i,
  output pd_samples_t smp_o,
  output logic        ctr_o
);

  logic bnd_q;
  logic bnd_hold_q;
  logic ctr_q;
  logic prev_q;

  // boundary sample taken mid-period on the falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bnd_q <= 1'b0;
    else         bnd_q <= data_i;
  end

  // centre samples and boundary realigned to the rising edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctr_q      <= 1'b0;
      prev_q     <= 1'b0;
      bnd_hold_q <= 1'b0;
    end else begin
      ctr_q      <= data_i;
      prev_q     <= ctr_q;
      bnd_hold_q <= bnd_q;
    end
  end

  assign smp_o = '{prev_ctr: prev_q, bnd: bnd_hold_q, cur_ctr: ctr_q};
  assign ctr_o = ctr_q;

endmodule

// File: rtl/pd_decide.sv
module pd_decide
  import lin_el_pd_pkg::*;
(
  input  pd_samples_t smp_i,
  output pd_dir_e     dir_o
);

  logic trans;
  logic bnd_eq_old;
  logic bnd_ne_old;

  always_comb begin
    trans      = smp_i.prev_ctr ^ smp_i.cur_ctr;
    bnd_eq_old = ~(smp_i.bnd ^ smp_i.prev_ctr);
    bnd_ne_old = smp_i.bnd ^ smp_i.prev_ctr;
    dir_o      = PD_NONE;
    if (trans && bnd_eq_old)      dir_o = PD_EARLY;
    else if (trans && bnd_ne_old) dir_o = PD_LATE;
  end

endmodule

// File: rtl/pd_gate.sv
module pd_gate
  import lin_el_pd_pkg::*;
(
  input  pd_dir_e dir_i,
  input  logic    data_i,
  input  logic    ctr_i,
  output logic    early_o,
  output logic    late_o
);

  logic mismatch;

  // live data against its last centre sample sets the pulse width
  assign mismatch = data_i ^ ctr_i;
  assign early_o  = (dir_i == PD_EARLY) && mismatch;
  assign late_o   = (dir_i == PD_LATE)  && mismatch;

endmodule

// File: rtl/lin_el_pd.sv
module lin_el_pd
  import lin_el_pd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  output logic early_o,
  output logic late_o
);

  pd_samples_t smp;
  logic        ctr;
  pd_dir_e     dir;

  pd_sampler i_sampler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .smp_o  (smp),
    .ctr_o  (ctr)
  );

  pd_decide i_decide (
    .smp_i (smp),
    .dir_o (dir)
  );

  pd_gate i_gate (
    .dir_i   (dir),
    .data_i  (data_i),
    .ctr_i   (ctr),
    .early_o (early_o),
    .late_o  (late_o)
  );

endmodule

// File: rtl/lin_el_pd_chk.sv
module lin_el_pd_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic data_i,
  input logic early_o,
  input logic late_o
);

  logic [1:0] warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            warm_q <= 2'd0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!early_o && !late_o)); // R1

  AST_NO_TRANSITION_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3 && $past(data_i) == $past(data_i, 2)) |-> (!early_o && !late_o)); // R2

  AST_ONE_DIRECTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(early_o && late_o)); // R5

  AST_NO_CHANGE_NO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3 && data_i == $past(data_i)) |-> (!early_o && !late_o)); // R6

endmodule

bind lin_el_pd lin_el_pd_chk i_chk (.*);

// File: tb/test_lin_el_pd.sv
`timescale 1ns/100ps
module test_lin_el_pd;

  localparam real CLK_PERIOD = 10.0;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic data_i = 1'b0;
  logic early_o;
  logic late_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  lin_el_pd i_lin_el_pd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .data_i  (data_i),
    .early_o (early_o),
    .late_o  (late_o)
  );

  always #(CLK_PERIOD / 2.0) clk_i = ~clk_i;

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // off<0: hold data; else toggle data at posedge+off. Counts high samples per period.
  task automatic run_cycles(int off, int n, int warm, int exp_e, int exp_l, string req);
    for (int c = 0; c < n; c++) begin
      int ne = 0;
      int nl = 0;
      int nb = 0;
      @(posedge clk_i);
      for (int i = 0; i < 10; i++) begin
        if (off >= 0 && i == off) data_i = ~data_i;
        #0.5;
        if (early_o) ne++;
        if (late_o) nl++;
        if (early_o && late_o) nb++;
        if (i < 9) #0.5;
      end
      if (c >= warm) begin
        check(ne == exp_e, {req, " early width"}, ne, exp_e);
        check(nl == exp_l, {req, " late width"}, nl, exp_l);
      end
      check(nb == 0, "R5 both high", nb, 0);
    end
  endtask

  task automatic t_reset;
    #2.2;
    check(!early_o && !late_o, "R1 outputs in reset", {early_o, late_o}, 0);
    data_i = 1'b1;
    #20;
    check(!early_o && !late_o, "R1 outputs in reset with data", {early_o, late_o}, 0);
    data_i = 1'b0;
    @(posedge clk_i); #2;
    rst_ni = 1'b1;
    run_cycles(-1, 3, 0, 0, 0, "R1 quiet after release");
  endtask

  task automatic t_quiet;
    run_cycles(7, 1, 0, 0, 0, "R7 change after equal centres");
    run_cycles(-1, 5, 0, 0, 0, "R2 constant data");
  endtask

  task automatic t_early;
    run_cycles(7, 6, 1, 3, 0, "R3 early polarity");
  endtask

  task automatic t_late;
    run_cycles(3, 6, 1, 0, 7, "R4 late polarity");
  endtask

  task automatic t_width;
    run_cycles(6, 4, 1, 4, 0, "R6 early width off6");
    run_cycles(8, 4, 1, 2, 0, "R6 early width off8");
    run_cycles(2, 4, 1, 0, 8, "R6 late width off2");
    run_cycles(4, 4, 1, 0, 6, "R6 late width off4");
  endtask

  task automatic t_isolated;
    run_cycles(-1, 3, 0, 0, 0, "R2 hold before single edge");
    run_cycles(3, 1, 0, 0, 0, "R7 isolated late edge");
    run_cycles(-1, 1, 0, 0, 0, "R6 decision without data change");
    run_cycles(-1, 2, 0, 0, 0, "R2 hold after single edge");
  endtask

  task automatic t_async_reset;
    run_cycles(7, 3, 1, 3, 0, "R3 early before reset");
    @(posedge clk_i);
    #7 data_i = ~data_i;
    #0.5;
    check(early_o == 1'b1, "R3 early pulse before reset", early_o, 1);
    #0.5 rst_ni = 1'b0;
    #0.2;
    check(!early_o && !late_o, "R1 async clear mid pulse", {early_o, late_o}, 0);
    @(posedge clk_i); #2;
    data_i = 1'b0;
    rst_ni = 1'b1;
    run_cycles(-1, 3, 0, 0, 0, "R1 quiet after second release");
  endtask

  initial begin
    t_reset();
    t_quiet();
    t_early();
    t_late();
    t_width();
    t_isolated();
    t_async_reset();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule